// File: doc/BRIEF.md
# Alternating-Boundary Duplicated-Bit Link Codec

This block is the transmit and receive halves of one on-chip network link. Each flit bit travels on two neighbouring wires, and one extra wire carries the even parity of the flit. The parity wire sits at the low end of the link on one transfer and at the high end on the next. Because of this, two back-to-back code words never drive the same edge wire with the parity bit. The receiver tracks the same alternation, takes the parity from the right end, and corrects any single flipped wire.

The encoder registers each valid flit into a 2n+1-bit link word. The decoder registers the corrected n-bit flit one cycle after it accepts a link word. One synchronous active-low reset puts both halves in step. Idle cycles change nothing on either side.

Top module: `bsc_link_codec`

## Requirements
- R1: While reset is low at a clock edge, link_word, link_valid, rx_flit and rx_flit_valid all become 0, and both alternation phases return to 0.
- R2: A phase-0 word (the first valid transfer after reset, then every other one) carries the even parity of the flit at bit 0, and flit bit i at both bit 2i+1 and bit 2i+2.
- R3: A phase-1 word is the phase-0 word rotated by one place so that the parity moves from bit 0 to bit 2n. Flit bit i then sits at both bit 2i and bit 2i+1.
- R4: The encoder phase toggles on each valid transfer and on nothing else, so consecutive valid words alternate their parity end regardless of idle gaps.
- R5: link_valid is tx_valid delayed by one cycle. After a cycle with tx_valid low, link_word keeps its previous value.
- R6: The decoder phase starts at 0 and toggles only on cycles with rx_valid high. Words presented while rx_valid is low do not affect it.
- R7: For a word taken in the matching phase with at most one wire flipped, rx_flit equals the original flit. The decoder rule: if the parity of the lower copy matches the parity wire, it outputs the lower copy; otherwise it outputs the upper copy.
- R8: rx_flit_valid is rx_valid delayed by one cycle. After a cycle with rx_valid low, rx_flit keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tx_flit | input | FLIT_W | Flit to encode |
| tx_valid | input | 1 | tx_flit is valid this cycle |
| link_word | output | 2*FLIT_W+1 | Encoded word driven onto the link |
| link_valid | output | 1 | link_word holds a new word |
| rx_word | input | 2*FLIT_W+1 | Word received from the link |
| rx_valid | input | 1 | rx_word is valid this cycle |
| rx_flit | output | FLIT_W | Decoded, corrected flit |
| rx_flit_valid | output | 1 | rx_flit holds a new flit |

## Verification
The bench builds the codec with FLIT_W = 8, which gives a 17-wire link. At that width it can walk a single flipped wire through every position in both phases, including the two edge wires that alternate between data and parity. The encoder output loops back into the decoder through a flip mask, with random gaps in valid. During those gaps, garbage and flips go onto the receive side to show the decoder phase ignores them. All-zero and all-ones flits exercise the parity extremes.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

   typedef enum logic {
      PH_PAR_LOW  = 1'b0,
      PH_PAR_HIGH = 1'b1
   } par_end_e;

   function automatic par_end_e next_end(input par_end_e cur);
      return (cur == PH_PAR_LOW) ? PH_PAR_HIGH : PH_PAR_LOW;
   endfunction

endpackage

// File: rtl/bsc_phase_track.sv
module bsc_phase_track
   import bsc_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     advance,
   output par_end_e cur_end
);

   par_end_e end_q;

   always_ff @(posedge clk) begin
      if (!rst_n)       end_q <= PH_PAR_LOW;
      else if (advance) end_q <= next_end(end_q);
   end

   assign cur_end = end_q;

endmodule

// File: rtl/bsc_encoder.sv
module bsc_encoder
   import bsc_pkg::*;
#(
   parameter int FLIT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [FLIT_W-1:0]   flit,
   input  logic                flit_vld,
   output logic [2*FLIT_W:0]   word,
   output logic                word_vld
);

   localparam int DUP_W  = 2 * FLIT_W;
   localparam int LINK_W = DUP_W + 1;

   logic [DUP_W-1:0]  dup;
   logic              par;
   logic [LINK_W-1:0] word_low, word_high;
   par_end_e          cur_end;

   for (genvar i = 0; i < FLIT_W; i++) begin : g_dup
      assign dup[2*i]   = flit[i];
      assign dup[2*i+1] = flit[i];
   end

   assign par       = ^flit;
   assign word_low  = {dup, par};
   assign word_high = {par, dup};

   bsc_phase_track u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (flit_vld),
      .cur_end (cur_end)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         word     <= '0;
         word_vld <= 1'b0;
      end else begin
         word_vld <= flit_vld;
         if (flit_vld)
            word <= (cur_end == PH_PAR_LOW) ? word_low : word_high;
      end
   end

endmodule

// File: rtl/bsc_decoder.sv
module bsc_decoder
   import bsc_pkg::*;
#(
   parameter int FLIT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [2*FLIT_W:0]   word,
   input  logic                word_vld,
   output logic [FLIT_W-1:0]   flit,
   output logic                flit_vld
);

   localparam int DUP_W = 2 * FLIT_W;

   par_end_e          cur_end;
   logic [DUP_W-1:0]  dup;
   logic              par_rx;
   logic [FLIT_W-1:0] copy_lo, copy_hi, pick;

   bsc_phase_track u_phase (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (word_vld),
      .cur_end (cur_end)
   );

   // strip the parity wire from whichever end carries it this phase
   assign dup    = (cur_end == PH_PAR_LOW) ? word[DUP_W:1] : word[DUP_W-1:0];
   assign par_rx = (cur_end == PH_PAR_LOW) ? word[0]       : word[DUP_W];

   for (genvar i = 0; i < FLIT_W; i++) begin : g_split
      assign copy_lo[i] = dup[2*i];
      assign copy_hi[i] = dup[2*i+1];
   end

   assign pick = ((^copy_lo) == par_rx) ? copy_lo : copy_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flit     <= '0;
         flit_vld <= 1'b0;
      end else begin
         flit_vld <= word_vld;
         if (word_vld) flit <= pick;
      end
   end

endmodule

// File: rtl/bsc_link_codec.sv
module bsc_link_codec #(
   parameter int FLIT_W = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [FLIT_W-1:0]   tx_flit,
   input  logic                tx_valid,
   output logic [2*FLIT_W:0]   link_word,
   output logic                link_valid,
   input  logic [2*FLIT_W:0]   rx_word,
   input  logic                rx_valid,
   output logic [FLIT_W-1:0]   rx_flit,
   output logic                rx_flit_valid
);

   if (FLIT_W < 1) begin : g_bad_width
      $error("bsc_link_codec: FLIT_W must be at least 1");
   end

   bsc_encoder #(.FLIT_W(FLIT_W)) u_enc (
      .clk      (clk),
      .rst_n    (rst_n),
      .flit     (tx_flit),
      .flit_vld (tx_valid),
      .word     (link_word),
      .word_vld (link_valid)
   );

   bsc_decoder #(.FLIT_W(FLIT_W)) u_dec (
      .clk      (clk),
      .rst_n    (rst_n),
      .word     (rx_word),
      .word_vld (rx_valid),
      .flit     (rx_flit),
      .flit_vld (rx_flit_valid)
   );

endmodule

// File: rtl/bsc_link_codec_chk.sv
module bsc_link_codec_chk #(
   parameter int FLIT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tx_valid,
   input logic [2*FLIT_W:0] link_word,
   input logic              link_valid,
   input logic              rx_valid,
   input logic [FLIT_W-1:0] rx_flit,
   input logic              rx_flit_valid
);

   localparam int LINK_W = 2 * FLIT_W + 1;

   // independent count of words seen on the link
   logic seen_odd;
   always_ff @(posedge clk) begin
      if (!rst_n)          seen_odd <= 1'b0;
      else if (link_valid) seen_odd <= ~seen_odd;
   end

   logic low_ok, high_ok;
   always_comb begin
      logic px_lo, px_hi;
      low_ok  = 1'b1;
      high_ok = 1'b1;
      px_lo   = 1'b0;
      px_hi   = 1'b0;
      for (int i = 0; i < FLIT_W; i++) begin
         if (link_word[2*i+1] != link_word[2*i+2]) low_ok  = 1'b0;
         if (link_word[2*i]   != link_word[2*i+1]) high_ok = 1'b0;
         px_lo = px_lo ^ link_word[2*i+1];
         px_hi = px_hi ^ link_word[2*i];
      end
      if (px_lo != link_word[0])        low_ok  = 1'b0;
      if (px_hi != link_word[LINK_W-1]) high_ok = 1'b0;
   end

   a_r5_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid |=> link_valid);
   a_r5_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_valid |=> (!link_valid && $stable(link_word)));
   a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> rx_flit_valid);
   a_r8_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_valid |=> (!rx_flit_valid && $stable(rx_flit)));
   a_r2_low_layout: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid && !seen_odd) |-> low_ok);
   a_r3_high_layout: assert property (@(posedge clk) disable iff (!rst_n)
      (link_valid && seen_odd) |-> high_ok);

endmodule

bind bsc_link_codec bsc_link_codec_chk #(.FLIT_W(FLIT_W)) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .tx_valid      (tx_valid),
   .link_word     (link_word),
   .link_valid    (link_valid),
   .rx_valid      (rx_valid),
   .rx_flit       (rx_flit),
   .rx_flit_valid (rx_flit_valid)
);

// File: tb/bsc_link_codec_bench.sv
module bsc_link_codec_bench;

   localparam int W = 8;
   localparam int L = 2 * W + 1;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [W-1:0] tx_flit = '0;
   logic         tx_valid = 1'b0;
   logic [L-1:0] link_word;
   logic         link_valid;
   logic [L-1:0] flip = '0;
   logic [L-1:0] rx_word;
   logic         rx_valid;
   logic [W-1:0] rx_flit;
   logic         rx_flit_valid;

   always #5 clk = ~clk;

   // loopback with injected wire flips; receive valid follows link valid
   assign rx_word  = link_word ^ flip;
   assign rx_valid = link_valid;

   bsc_link_codec #(.FLIT_W(W)) u_bsc_link_codec (
      .clk           (clk),
      .rst_n         (rst_n),
      .tx_flit       (tx_flit),
      .tx_valid      (tx_valid),
      .link_word     (link_word),
      .link_valid    (link_valid),
      .rx_word       (rx_word),
      .rx_valid      (rx_valid),
      .rx_flit       (rx_flit),
      .rx_flit_valid (rx_flit_valid)
   );

   int checks = 0;
   int failures = 0;

   logic [W-1:0] exp_q[$];
   bit           tph = 1'b0;
   logic [W-1:0] pend = '0;
   bit           prev_tx_v = 1'b0;
   bit           prev_link_v = 1'b0;
   logic [L-1:0] last_link = '0;
   logic [W-1:0] last_rx = '0;

   task automatic check(bit ok, string req, logic [L-1:0] act, logic [L-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [L-1:0] enc(bit ph, logic [W-1:0] d);
      logic [L-1:0] w;
      w = '0;
      for (int i = 0; i < W; i++) begin
         if (!ph) begin w[2*i+1] = d[i]; w[2*i+2] = d[i]; end
         else     begin w[2*i]   = d[i]; w[2*i+1] = d[i]; end
      end
      if (!ph) w[0] = ^d; else w[L-1] = ^d;
      return w;
   endfunction

   // one cycle: check what the last edge produced, then drive the next inputs
   task automatic cycle(bit v, logic [W-1:0] d, bit inj, int pos);
      logic [L-1:0] one;
      @(negedge clk);
      one = 1;
      check(rx_flit_valid == prev_link_v, "R8 latency", L'(rx_flit_valid), L'(prev_link_v));
      if (rx_flit_valid) begin
         if (exp_q.size() == 0) check(1'b0, "R7 extra flit", L'(rx_flit), '0);
         else begin
            logic [W-1:0] e;
            e = exp_q.pop_front();
            check(rx_flit == e, "R7 R6 decoded flit", L'(rx_flit), L'(e));
         end
      end else begin
         check(rx_flit == last_rx, "R8 idle hold", L'(rx_flit), L'(last_rx));
      end
      last_rx = rx_flit;
      check(link_valid == prev_tx_v, "R5 latency", L'(link_valid), L'(prev_tx_v));
      if (link_valid) begin
         check(link_word == enc(tph, pend), tph ? "R3 R4 high-end word" : "R2 R4 low-end word",
               link_word, enc(tph, pend));
         tph = ~tph;
         exp_q.push_back(pend);
      end else begin
         check(link_word == last_link, "R5 idle hold", link_word, last_link);
      end
      last_link   = link_word;
      prev_link_v = link_valid;
      flip        = inj ? (one << pos) : '0;
      tx_valid    = v;
      tx_flit     = d;
      prev_tx_v   = v;
      if (v) pend = d;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog requirement=all actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      rst_n = 1'b0;
      tx_valid = 1'b1;
      tx_flit = 8'hA5;
      repeat (3) @(negedge clk);
      // R1: reset clears outputs even with tx_valid driven high
      check(link_word == '0 && !link_valid, "R1 encoder reset", link_word, '0);
      check(rx_flit == '0 && !rx_flit_valid, "R1 decoder reset", L'(rx_flit), '0);
      tx_valid = 1'b0;
      rst_n = 1'b1;

      // parity extremes and back-to-back phases
      cycle(1, 8'h00, 0, 0);
      cycle(1, 8'hFF, 0, 0);
      cycle(1, 8'hFF, 0, 0);
      cycle(1, 8'h01, 0, 0);
      cycle(0, 8'h00, 0, 0);

      // every single-wire flip in both phases
      for (int p = 0; p < L; p++) begin
         cycle(1, 8'(p * 37 + 5), 0, 0);
         cycle(1, 8'(p * 91 + 3), 1, p);
         cycle(0, 8'h00, 1, p);
      end
      for (int p = 0; p < L; p++) begin
         cycle(1, 8'(p * 53 + 1), 1, p);
         cycle(0, 8'h00, 0, 0);
      end

      // idle cycles with garbage on the receive wires must not shift R6 phase
      cycle(0, 8'h3C, 1, 0);
      cycle(0, 8'hC3, 1, L - 1);
      cycle(0, 8'h00, 1, 5);

      // random stream with gaps
      for (int n = 0; n < 4000; n++) begin
         bit v, inj;
         v   = ($urandom % 10) < 6;
         inj = ($urandom % 2) == 1;
         cycle(v, 8'($urandom), inj, int'($urandom % L));
      end

      repeat (3) cycle(0, 8'h00, 0, 0);
      check(exp_q.size() == 0, "R8 all flits delivered", L'(exp_q.size()), '0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule